// File: doc/BRIEF.md
# Nibble Load/Exchange Execution Unit

This unit executes the 4-bit data movement instructions of a small nibble-wide processor core. It holds three nibble registers (A, B and the flag nibble F, whose bit 3 is the E flag) and two 16-bit address pointers X and Y. Each instruction arrives as a 13-bit word on a valid/ready input. The unit drives a nibble-wide data memory port whose writes commit on the rising clock edge and whose read data is returned combinationally in the same cycle as the address.

Most instructions finish in the cycle they are accepted. Memory-to-memory copies and exchanges between a register and memory take two cycles: the first reads memory into a holding nibble, the second writes. During the second cycle `busy` is high and `instr_ready` is low. An instruction is accepted on a rising edge where `instr_valid` and `instr_ready` are both high. While `instr_ready` is low, the upstream must hold the word and keep `instr_valid` high; nothing is consumed. Words that are not in the group are consumed as no-operations and flagged on `illegal`.

Pointers X and Y leave reset at the parameter values `X_INIT` and `Y_INIT`. They change only by post-increment.

Top module: `nx_xfer_unit`

## Requirements
- R1: After reset, A, B and F are 0, X equals X_INIT, Y equals Y_INIT, `busy`, `illegal` and `mem_we` are 0, and `instr_ready` is 1.
- R2: These one-cycle register moves are supported (bits 12..0):
  - 1111011110000: A from A.
  - 1111011110010: A from B.
  - 1111011110100: B from A.
  - 1111011110110: B from B.
  - 1111111110110: A from F.
  - 1111111110101: F from A.
  - 111101100iiii: A from imm4.
  - 111101101iiii: B from imm4.
  - 100001011iiii: F from imm4.
  - 1111111110111: A and B exchange in one cycle.
- R3: Loads from memory use 1111011100rpi. r selects the register (0 = A, 1 = B), p selects the pointer (0 = X, 1 = Y), and i=1 increments that pointer after the read. Each load takes one cycle.
- R4: Stores to memory take one cycle and write to the location the chosen pointer addresses. A register store uses 1111011101rpi, with r, p and i as in R3. An immediate store uses 1111010pi followed by imm4.
- R5: Memory-to-memory copies use 1111011111dqs and take two cycles. q=1 makes the destination X with source Y, and q=0 makes the destination Y with source X. d=1 increments the destination pointer and s=1 increments the source pointer, each after its own access.
- R6: Exchanges between a register and memory use 1000011111rpi, with r, p and i as in R3. Each takes two cycles and swaps the register with the addressed nibble. It then applies the post-increment.
- R7: Loads into F write all four bits of F. Every other accepted instruction of the group clears F bit 3 (E) and leaves F bits 2..0 unchanged.
- R8: A pointer increment wraps from 16'hFFFF to 16'h0000.
- R9: `busy` is high for exactly the one cycle after a two-cycle instruction is accepted, and `instr_ready` is its inverse. No word is accepted while `instr_valid` is low or `instr_ready` is low.
- R10: An accepted word outside the group changes no register, pointer, flag or memory location. `illegal` is high for the one cycle after it is accepted.
- R11: `mem_we` is high only in a cycle that writes memory. In the second cycle of a copy, `mem_addr` is the destination pointer and `mem_wdata` is the nibble read in the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present |
| instr_ready | output | 1 | Unit can take a word this cycle |
| instr | input | 13 | Instruction word |
| busy | output | 1 | Second cycle of a two-cycle instruction |
| illegal | output | 1 | One-cycle pulse after an unrecognised word |
| mem_addr | output | 16 | Data memory address |
| mem_wdata | output | 4 | Data memory write nibble |
| mem_we | output | 1 | Data memory write enable |
| mem_rdata | input | 4 | Data memory read nibble, same cycle as address |
| reg_a | output | 4 | Register A |
| reg_b | output | 4 | Register B |
| reg_f | output | 4 | Flag nibble F (bit 3 is E) |
| ptr_x | output | 16 | Pointer X |
| ptr_y | output | 16 | Pointer Y |

## Verification
A one-cycle instruction shows its register, pointer and memory results just after the edge that accepts it. `busy` and `illegal` also become visible at that edge. A two-cycle instruction shows its results only after the following edge. The bench drives each word at a falling edge and samples 1 ns after the accepting edge. There it checks `busy` and `illegal`, waits one further edge when `busy` is high, and then compares the registers, the pointers and the memory model. A directed case holds a new word on the input through a busy cycle and confirms it is taken one edge late. The same case samples the memory port during the second cycle of a copy.

// File: rtl/nx_pkg.sv
package nx_pkg;
  localparam int NX_IW = 13;
  localparam int NX_DW = 4;
  localparam int NX_AW = 16;

  typedef enum logic [2:0] {
    OP_LDR, OP_LDM, OP_ST, OP_CPY, OP_XAB, OP_XM, OP_ILL
  } op_kind_e;

  typedef enum logic [1:0] {RS_A, RS_B, RS_F, RS_IMM} rsel_e;

  typedef struct packed {
    op_kind_e         kind;
    rsel_e            dreg;     // destination / exchange register
    rsel_e            sreg;     // source register for moves and stores
    logic             ptr;      // 0 = X, 1 = Y (destination pointer for copies)
    logic             pinc;     // post-increment of ptr
    logic             qinc;     // post-increment of the other pointer (copy source)
    logic [NX_DW-1:0] imm;
    logic             two_cyc;
    logic             f_load;
  } op_t;
endpackage

// File: rtl/nx_decode.sv
module nx_decode
  import nx_pkg::*;
(
  input  logic [NX_IW-1:0] instr,
  output op_t              op
);
  logic [5:0] c;
  assign c = instr[5:0];

  always_comb begin
    op      = '0;
    op.kind = OP_ILL;
    op.dreg = RS_A;
    op.sreg = RS_A;
    op.imm  = instr[NX_DW-1:0];
    if (instr[12:6] == 7'b1111011) begin
      unique case (c[5:4])
        2'b00: begin op.kind = OP_LDR; op.dreg = RS_A; op.sreg = RS_IMM; end
        2'b01: begin op.kind = OP_LDR; op.dreg = RS_B; op.sreg = RS_IMM; end
        2'b10: begin
          op.ptr  = c[1];
          op.pinc = c[0];
          if (!c[3]) begin
            op.kind = OP_LDM;
            op.dreg = c[2] ? RS_B : RS_A;
          end else begin
            op.kind = OP_ST;
            op.sreg = c[2] ? RS_B : RS_A;
          end
        end
        default: begin
          if (!c[3]) begin
            if (!c[0]) begin
              op.kind = OP_LDR;
              op.dreg = c[2] ? RS_B : RS_A;
              op.sreg = c[1] ? RS_B : RS_A;
            end
          end else begin
            op.kind = OP_CPY;
            op.ptr  = ~c[1];
            op.pinc = c[2];
            op.qinc = c[0];
          end
        end
      endcase
    end else if (instr[12:6] == 7'b1111010) begin
      op.kind = OP_ST;
      op.sreg = RS_IMM;
      op.ptr  = c[5];
      op.pinc = c[4];
    end else if (instr[12:4] == 9'b111111111) begin
      unique case (instr[3:0])
        4'b0110: begin op.kind = OP_LDR; op.dreg = RS_A; op.sreg = RS_F; end
        4'b0101: begin op.kind = OP_LDR; op.dreg = RS_F; op.sreg = RS_A; op.f_load = 1'b1; end
        4'b0111: op.kind = OP_XAB;
        default: op.kind = OP_ILL;
      endcase
    end else if (instr[12:4] == 9'b100001011) begin
      op.kind   = OP_LDR;
      op.dreg   = RS_F;
      op.sreg   = RS_IMM;
      op.f_load = 1'b1;
    end else if (instr[12:4] == 9'b100001111 && instr[3]) begin
      op.kind = OP_XM;
      op.dreg = instr[2] ? RS_B : RS_A;
      op.ptr  = instr[1];
      op.pinc = instr[0];
    end
    op.two_cyc = (op.kind == OP_CPY) || (op.kind == OP_XM);
  end
endmodule

// File: rtl/nx_ptr.sv
module nx_ptr #(
  parameter int AW = 16,
  parameter logic [AW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [AW-1:0] val
);
  always_ff @(posedge clk) begin
    if (!rst_n)   val <= INIT;
    else if (inc) val <= val + 1'b1;
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (val != $past(val)) |-> (val == AW'($past(val) + 1'b1))); // R8
endmodule

// File: rtl/nx_nibregs.sv
module nx_nibregs #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [DW-1:0] a_d,
  input  logic          b_we,
  input  logic [DW-1:0] b_d,
  input  logic          f_we,
  input  logic [DW-1:0] f_d,
  input  logic          e_clr,
  output logic [DW-1:0] a,
  output logic [DW-1:0] b,
  output logic [DW-1:0] f
);
  localparam int EBIT = DW - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a <= '0;
      b <= '0;
      f <= '0;
    end else begin
      if (a_we) a <= a_d;
      if (b_we) b <= b_d;
      if (f_we)       f <= f_d;
      else if (e_clr) f[EBIT] <= 1'b0;
    end
  end

  AST_E_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((f != $past(f)) && !$past(f_we)) |-> (f == {1'b0, $past(f[EBIT-1:0])})); // R7
endmodule

// File: rtl/nx_xfer_unit.sv
module nx_xfer_unit
  import nx_pkg::*;
#(
  parameter logic [NX_AW-1:0] X_INIT = '0,
  parameter logic [NX_AW-1:0] Y_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  output logic             instr_ready,
  input  logic [NX_IW-1:0] instr,
  output logic             busy,
  output logic             illegal,
  output logic [NX_AW-1:0] mem_addr,
  output logic [NX_DW-1:0] mem_wdata,
  output logic             mem_we,
  input  logic [NX_DW-1:0] mem_rdata,
  output logic [NX_DW-1:0] reg_a,
  output logic [NX_DW-1:0] reg_b,
  output logic [NX_DW-1:0] reg_f,
  output logic [NX_AW-1:0] ptr_x,
  output logic [NX_AW-1:0] ptr_y
);
  op_t              dec_op, op_q, cur;
  logic             busy_q, ill_q, accept;
  logic [NX_DW-1:0] tmp_q, sval;
  logic [NX_AW-1:0] pv, qv;
  logic             a_we, b_we, f_we, e_clr, inc_p, inc_q, x_inc, y_inc;
  logic [NX_DW-1:0] a_d, b_d, f_d;

  nx_decode u_dec (.instr(instr), .op(dec_op));

  assign instr_ready = ~busy_q;
  assign accept      = instr_valid & ~busy_q;
  assign cur         = busy_q ? op_q : dec_op;
  assign pv          = cur.ptr ? ptr_y : ptr_x;
  assign qv          = cur.ptr ? ptr_x : ptr_y;

  always_comb begin
    unique case (cur.sreg)
      RS_A:    sval = reg_a;
      RS_B:    sval = reg_b;
      RS_F:    sval = reg_f;
      default: sval = cur.imm;
    endcase
  end

  always_comb begin
    a_we = 1'b0; a_d = sval;
    b_we = 1'b0; b_d = sval;
    f_we = 1'b0; f_d = sval;
    e_clr = 1'b0; inc_p = 1'b0; inc_q = 1'b0;
    mem_addr = pv; mem_we = 1'b0; mem_wdata = sval;
    if (busy_q) begin
      if (cur.kind == OP_CPY) begin
        mem_we    = 1'b1;
        mem_wdata = tmp_q;
        inc_p     = cur.pinc;
      end else if (cur.kind == OP_XM) begin
        mem_we = 1'b1;
        inc_p  = cur.pinc;
        if (cur.dreg == RS_B) begin
          mem_wdata = reg_b; b_we = 1'b1; b_d = tmp_q;
        end else begin
          mem_wdata = reg_a; a_we = 1'b1; a_d = tmp_q;
        end
      end
    end else if (accept) begin
      e_clr = (cur.kind != OP_ILL) && !cur.f_load;
      unique case (cur.kind)
        OP_LDR: begin
          if (cur.dreg == RS_A)      a_we = 1'b1;
          else if (cur.dreg == RS_B) b_we = 1'b1;
          else                       f_we = 1'b1;
        end
        OP_LDM: begin
          inc_p = cur.pinc;
          if (cur.dreg == RS_B) begin b_we = 1'b1; b_d = mem_rdata; end
          else                  begin a_we = 1'b1; a_d = mem_rdata; end
        end
        OP_ST: begin
          mem_we = 1'b1;
          inc_p  = cur.pinc;
        end
        OP_CPY: begin
          mem_addr = qv;
          inc_q    = cur.qinc;
        end
        OP_XAB: begin
          a_we = 1'b1; a_d = reg_b;
          b_we = 1'b1; b_d = reg_a;
        end
        default: ;
      endcase
    end
  end

  assign x_inc = (inc_p & ~cur.ptr) | (inc_q & cur.ptr);
  assign y_inc = (inc_p & cur.ptr) | (inc_q & ~cur.ptr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ill_q  <= 1'b0;
      op_q   <= '0;
      tmp_q  <= '0;
    end else begin
      busy_q <= accept & cur.two_cyc;
      ill_q  <= accept & (cur.kind == OP_ILL);
      if (accept) begin
        op_q  <= dec_op;
        tmp_q <= mem_rdata;
      end
    end
  end

  assign busy    = busy_q;
  assign illegal = ill_q;

  nx_nibregs #(.DW(NX_DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .a_we(a_we), .a_d(a_d), .b_we(b_we), .b_d(b_d),
    .f_we(f_we), .f_d(f_d), .e_clr(e_clr),
    .a(reg_a), .b(reg_b), .f(reg_f)
  );

  nx_ptr #(.AW(NX_AW), .INIT(X_INIT)) u_px (
    .clk(clk), .rst_n(rst_n), .inc(x_inc), .val(ptr_x)
  );
  nx_ptr #(.AW(NX_AW), .INIT(Y_INIT)) u_py (
    .clk(clk), .rst_n(rst_n), .inc(y_inc), .val(ptr_y)
  );

  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R9
  AST_ILL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_op.kind == OP_ILL) |-> !mem_we); // R10
  AST_ILL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (reg_a == $past(reg_a) && reg_b == $past(reg_b) &&
                 reg_f == $past(reg_f) && ptr_x == $past(ptr_x) &&
                 ptr_y == $past(ptr_y))); // R10
  AST_BUSY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mem_we); // R11
endmodule

// File: tb/nx_xfer_unit_tb.sv
`timescale 1ns/1ps
module nx_xfer_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [12:0] instr = '0;
  logic        busy, illegal, mem_we;
  logic [15:0] mem_addr, ptr_x, ptr_y;
  logic [3:0]  mem_wdata, mem_rdata, reg_a, reg_b, reg_f;
  logic [3:0]  bmem [256];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nx_xfer_unit #(.X_INIT(16'hFFFE), .Y_INIT(16'h0040)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr(instr), .busy(busy), .illegal(illegal), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .reg_a(reg_a), .reg_b(reg_b), .reg_f(reg_f), .ptr_x(ptr_x), .ptr_y(ptr_y)
  );

  assign mem_rdata = bmem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;

  typedef struct packed {
    logic [12:0] ins;
    logic [3:0]  ea, eb, ef;
    logic [15:0] ex, ey;
    logic        mchk;
    logic [7:0]  maddr;
    logic [3:0]  mval;
    logic        two, ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{13'b1000010111111, 4'h0, 4'h0, 4'hF, 16'hFFFE, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd7},
    '{13'b1111011000011, 4'h3, 4'h0, 4'h7, 16'hFFFE, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd2},
    '{13'b1111011110100, 4'h3, 4'h3, 4'h7, 16'hFFFE, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd2},
    '{13'b1111011001001, 4'h9, 4'h3, 4'h7, 16'hFFFE, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd2},
    '{13'b1111011110010, 4'h3, 4'h3, 4'h7, 16'hFFFE, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd2},
    '{13'b1111011000101, 4'h5, 4'h3, 4'h7, 16'hFFFE, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd2},
    '{13'b1111111110111, 4'h3, 4'h5, 4'h7, 16'hFFFE, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd2},
    '{13'b1111011110000, 4'h3, 4'h5, 4'h7, 16'hFFFE, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd2},
    '{13'b1111011110110, 4'h3, 4'h5, 4'h7, 16'hFFFE, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd2},
    '{13'b1111111110110, 4'h7, 4'h5, 4'h7, 16'hFFFE, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd2},
    '{13'b1111011001100, 4'hC, 4'h5, 4'h7, 16'hFFFE, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd2},
    '{13'b1111111110101, 4'hC, 4'h5, 4'hC, 16'hFFFE, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd7},
    '{13'b1111011010010, 4'hC, 4'h2, 4'h4, 16'hFFFE, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd7},
    '{13'b1111011100000, 4'h9, 4'h2, 4'h4, 16'hFFFE, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd3},
    '{13'b1111011100001, 4'h9, 4'h2, 4'h4, 16'hFFFF, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd3},
    '{13'b1111011100101, 4'h9, 4'h3, 4'h4, 16'h0000, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd8},
    '{13'b1111011100010, 4'h5, 4'h3, 4'h4, 16'h0000, 16'h0040, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd3},
    '{13'b1111011100111, 4'h5, 4'h5, 4'h4, 16'h0000, 16'h0041, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd3},
    '{13'b1111011101001, 4'h5, 4'h5, 4'h4, 16'h0001, 16'h0041, 1'b1, 8'h00, 4'h5, 1'b0, 1'b0, 4'd4},
    '{13'b1111010111101, 4'h5, 4'h5, 4'h4, 16'h0001, 16'h0042, 1'b1, 8'h41, 4'hD, 1'b0, 1'b0, 4'd4},
    '{13'b1111011111011, 4'h5, 4'h5, 4'h4, 16'h0001, 16'h0043, 1'b1, 8'h01, 4'h6, 1'b1, 1'b0, 4'd5},
    '{13'b1111011111101, 4'h5, 4'h5, 4'h4, 16'h0002, 16'h0044, 1'b1, 8'h43, 4'h6, 1'b1, 1'b0, 4'd5},
    '{13'b1000010111000, 4'h5, 4'h5, 4'h8, 16'h0002, 16'h0044, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd7},
    '{13'b1111111111000, 4'h5, 4'h5, 4'h8, 16'h0002, 16'h0044, 1'b0, 8'h00, 4'h0, 1'b0, 1'b1, 4'd10},
    '{13'b1000011111001, 4'hB, 4'h5, 4'h0, 16'h0003, 16'h0044, 1'b1, 8'h02, 4'h5, 1'b1, 1'b0, 4'd6},
    '{13'b1000011111110, 4'hB, 4'h8, 4'h0, 16'h0003, 16'h0044, 1'b1, 8'h44, 4'h5, 1'b1, 1'b0, 4'd6},
    '{13'b1000011110011, 4'hB, 4'h8, 4'h0, 16'h0003, 16'h0044, 1'b0, 8'h00, 4'h0, 1'b0, 1'b1, 4'd10},
    '{13'b1111011110001, 4'hB, 4'h8, 4'h0, 16'h0003, 16'h0044, 1'b0, 8'h00, 4'h0, 1'b0, 1'b1, 4'd10},
    '{13'b1111011101100, 4'hB, 4'h8, 4'h0, 16'h0003, 16'h0044, 1'b1, 8'h03, 4'h8, 1'b0, 1'b0, 4'd4},
    '{13'b1111011101111, 4'hB, 4'h8, 4'h0, 16'h0003, 16'h0045, 1'b1, 8'h44, 4'h8, 1'b0, 1'b0, 4'd4},
    '{13'b1111011111000, 4'hB, 4'h8, 4'h0, 16'h0003, 16'h0045, 1'b1, 8'h45, 4'h8, 1'b1, 1'b0, 4'd5},
    '{13'b1111011111110, 4'hB, 4'h8, 4'h0, 16'h0004, 16'h0045, 1'b1, 8'h03, 4'h8, 1'b1, 1'b0, 4'd5},
    '{13'b1111010101010, 4'hB, 4'h8, 4'h0, 16'h0004, 16'h0045, 1'b1, 8'h45, 4'hA, 1'b0, 1'b0, 4'd4},
    '{13'b1111011100110, 4'hB, 4'hA, 4'h0, 16'h0004, 16'h0045, 1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 4'd3}
  };

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      4'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 4'h0;
    bmem[8'hFE] = 4'h9; bmem[8'hFF] = 4'h3; bmem[8'h00] = 4'hC;
    bmem[8'h01] = 4'h7; bmem[8'h02] = 4'hB; bmem[8'h40] = 4'h5;
    bmem[8'h41] = 4'hA; bmem[8'h42] = 4'h6; bmem[8'h43] = 4'hE;
    bmem[8'h44] = 4'h8;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1", "reg_a", 32'(reg_a), 32'h0);
    chk("R1", "reg_b", 32'(reg_b), 32'h0);
    chk("R1", "reg_f", 32'(reg_f), 32'h0);
    chk("R1", "ptr_x", 32'(ptr_x), 32'hFFFE);
    chk("R1", "ptr_y", 32'(ptr_y), 32'h0040);
    chk("R1", "busy/illegal/we/ready", {28'h0, busy, illegal, mem_we, instr_ready}, 32'h1);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      instr = VEC[k].ins;
      instr_valid = 1'b1;
      @(posedge clk);
      #1;
      instr_valid = 1'b0;
      chk("R9", "busy", 32'(busy), 32'(VEC[k].two));
      chk("R10", "illegal", 32'(illegal), 32'(VEC[k].ill));
      if (busy) begin
        @(posedge clk);
        #1;
      end
      chk(rname(VEC[k].req), "reg_a", 32'(reg_a), 32'(VEC[k].ea));
      chk(rname(VEC[k].req), "reg_b", 32'(reg_b), 32'(VEC[k].eb));
      chk(rname(VEC[k].req), "reg_f", 32'(reg_f), 32'(VEC[k].ef));
      chk(rname(VEC[k].req), "ptr_x", 32'(ptr_x), 32'(VEC[k].ex));
      chk(rname(VEC[k].req), "ptr_y", 32'(ptr_y), 32'(VEC[k].ey));
      if (VEC[k].mchk)
        chk(rname(VEC[k].req), "memory", 32'(bmem[VEC[k].maddr]), 32'(VEC[k].mval));
    end

    // R9: a word with valid low is not taken
    @(negedge clk);
    instr = 13'b1111011000001;
    instr_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "reg_a valid low", 32'(reg_a), 32'hB);
    chk("R11", "mem_we idle", 32'(mem_we), 32'h0);

    // R9/R11: back-pressure while a copy [Y]+ <- [X] finishes
    @(negedge clk);
    instr = 13'b1111011111100;
    instr_valid = 1'b1;
    @(posedge clk);
    #1;
    chk("R9", "ready during busy", 32'(instr_ready), 32'h0);
    chk("R11", "copy dest addr", 32'(mem_addr), 32'h0045);
    chk("R11", "copy write en", 32'(mem_we), 32'h1);
    chk("R11", "copy write data", 32'(mem_wdata), 32'h0);
    @(negedge clk);
    instr = 13'b1111011000001;
    @(posedge clk);
    #1;
    chk("R9", "held word not taken", 32'(reg_a), 32'hB);
    chk("R5", "copy pointer y", 32'(ptr_y), 32'h0046);
    chk("R5", "copy memory", 32'(bmem[8'h45]), 32'h0);
    @(posedge clk);
    #1;
    instr_valid = 1'b0;
    chk("R9", "held word taken late", 32'(reg_a), 32'h1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule